// File: doc/BRIEF.md
# Sector Erase Collection Window

This block gathers the sectors for one concurrent sector erase. A command front end, which decodes the unlock sequence, passes it one event per write-strobe edge: a one-cycle pulse on the falling edge and a one-cycle pulse on the rising edge. The rising-edge pulse carries the command byte and the address, and a flag marks the rising edge that completes a full sector-erase sequence. The first such completion selects a sector and opens a quiet window of `WIN_CYC` clock cycles. `WIN_CYC` is derived from the clock rate in MHz and the window length in microseconds.

While the window is open, each further write cycle that carries the sector command adds its sector to the bitmap. The window pauses when the strobe falls and restarts at full length when the strobe rises. If the window runs out with no new strobe, the block pulses an erase start and presents the selected-sector mask. The erase hold/suspend command is tolerated during the window. Any other command aborts the operation: the block pulses abort with the mask of the sectors that must be treated as invalid, then forgets them. A delay status bit reads low for as long as the window is open.

Top module: `sector_erase_window`

## Requirements
- R1: While `rst` is high, and after it is released, `erase_go_o` and `abort_o` are 0, `sel_mask_o` is all zeros, and `dq3_o` is 1.
- R2: In the idle state, a `wr_rise_i` pulse with `seq_ok_i`=1 and `cmd_i`=8'h30 opens the window, and `dq3_o` reads 0 from the next cycle. The sector index is the top log2(NSEC) bits of `addr_i`, so any address within a sector selects that sector. In idle, a rise without `seq_ok_i`, a rise with any other command, and any `wr_fall_i` change nothing.
- R3: If no `wr_fall_i` arrives, `erase_go_o` rises exactly `WIN_CYC` cycles after the cycle in which the last accepted rise was sampled. In that cycle `sel_mask_o` holds the selected sectors (bit i = sector i), `dq3_o` returns to 1, and the block is idle again.
- R4: A `wr_fall_i` while the window is open pauses the window for as long as the strobe stays low. No erase starts during the pause, however long it lasts. The next rise restarts a full `WIN_CYC` window.
- R5: A rise with `cmd_i`=8'h30 that ends a strobe begun inside the window adds the addressed sector. Sectors may be added in any order, up to all NSEC of them, and all of them appear in the mask.
- R6: Adding a sector that is already selected leaves the mask unchanged but still restarts the window.
- R7: A rise with `cmd_i`=8'hB0 inside the window leaves the mask unchanged, does not abort, and restarts the window.
- R8: A rise with any command other than 8'h30 or 8'hB0 inside the window pulses `abort_o` for one cycle on the next cycle, with `sel_mask_o` holding the sectors selected so far. `dq3_o` returns to 1, the mask is cleared, and no erase follows.
- R9: A `wr_fall_i` sampled in the same cycle that the window expires does not join: the erase starts with the existing mask.
- R10: `erase_go_o` and `abort_o` are single-cycle pulses that are never high together, and `sel_mask_o` is zero whenever neither pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_fall_i | input | 1 | One-cycle pulse on a write-strobe falling edge |
| wr_rise_i | input | 1 | One-cycle pulse on a write-strobe rising edge |
| seq_ok_i | input | 1 | With the rise: this cycle completes a sector-erase sequence |
| cmd_i | input | 8 | Command byte latched with the rise |
| addr_i | input | ADDR_W | Address latched with the rise |
| erase_go_o | output | 1 | One-cycle erase start |
| abort_o | output | 1 | One-cycle abort; the mask lists sectors now invalid |
| sel_mask_o | output | NSEC | Sector mask, valid with either pulse |
| dq3_o | output | 1 | Delay status; low while the window is open |

## Verification
The hardest situation to create is an edge race against expiry: a strobe falling in exactly the cycle the window runs out, where the erase must win. The stimulus reaches this by counting cycles from the sampled rise and placing the fall pulse on the `WIN_CYC`-th edge. A second hard case is a strobe held low for several window lengths, which shows that a pause never expires. A behavioural model tracks state, countdown and mask in plain integers and is compared on every cycle. Directed checks also measure the exact delay from the last rise to the erase start.

// File: rtl/sew_pkg.sv
package sew_pkg;
  localparam logic [7:0] CMD_SECTOR = 8'h30;
  localparam logic [7:0] CMD_HOLD   = 8'hB0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_LOW  = 2'd2
  } sew_state_t;
endpackage

// File: rtl/sew_sector_decode.sv
module sew_sector_decode #(
  parameter int ADDR_W = 19,
  parameter int NSEC   = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NSEC-1:0]   onehot_o
);
  localparam int IDX_W = (NSEC > 1) ? $clog2(NSEC) : 1;

  logic [IDX_W-1:0] idx;
  assign idx = addr_i[ADDR_W-1 -: IDX_W];

  generate
    for (genvar g = 0; g < NSEC; g++) begin : g_bit
      assign onehot_o[g] = (idx == IDX_W'(g));
    end
  endgenerate
endmodule

// File: rtl/sew_window_timer.sv
module sew_window_timer #(
  parameter int WIN_CYC = 16000
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WIN_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (load_i)                cnt <= RELOAD;
    else if (run_i && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired_o = (cnt == '0);

  // R3: the countdown never exceeds one window
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= RELOAD);
  // R4: a paused window keeps its count
  assert_pause_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !load_i) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/sew_mask_accum.sv
module sew_mask_accum #(
  parameter int NSEC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear_i,
  input  logic            set_i,
  input  logic [NSEC-1:0] add_i,
  output logic [NSEC-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i) mask_o <= '0;
    else if (set_i)     mask_o <= mask_o | add_i;
  end

  // R5: sectors are only ever added until the mask is cleared
  assert_mask_grow_R5: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> ((mask_o & $past(mask_o)) == $past(mask_o)));
endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window
  import sew_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int NSEC      = 8,
  parameter int CLK_MHZ   = 200,
  parameter int WINDOW_US = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fall_i,
  input  logic              wr_rise_i,
  input  logic              seq_ok_i,
  input  logic [7:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              erase_go_o,
  output logic              abort_o,
  output logic [NSEC-1:0]   sel_mask_o,
  output logic              dq3_o
);
  localparam int WIN_CYC = CLK_MHZ * WINDOW_US;

  sew_state_t      state, state_n;
  logic [NSEC-1:0] dec_onehot, acc_mask;
  logic            tmr_expired, tmr_load, tmr_run;
  logic            open_first, add_more, hold_cmd, bad_cmd, fire, fall_ok;

  sew_sector_decode #(.ADDR_W(ADDR_W), .NSEC(NSEC)) u_dec (
    .addr_i  (addr_i),
    .onehot_o(dec_onehot)
  );

  sew_window_timer #(.WIN_CYC(WIN_CYC)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load_i   (tmr_load),
    .run_i    (tmr_run),
    .expired_o(tmr_expired)
  );

  always_comb begin
    open_first = (state == ST_IDLE) && wr_rise_i && seq_ok_i && (cmd_i == CMD_SECTOR);
    fire       = (state == ST_OPEN) && tmr_expired;
    fall_ok    = (state == ST_OPEN) && wr_fall_i && !tmr_expired;
    add_more   = (state == ST_LOW) && wr_rise_i && (cmd_i == CMD_SECTOR);
    hold_cmd   = (state == ST_LOW) && wr_rise_i && (cmd_i == CMD_HOLD);
    bad_cmd    = (state == ST_LOW) && wr_rise_i && !add_more && !hold_cmd;
    tmr_load   = open_first || fall_ok || add_more || hold_cmd;
    tmr_run    = (state == ST_OPEN);

    state_n = state;
    unique case (state)
      ST_IDLE: if (open_first) state_n = ST_OPEN;
      ST_OPEN: begin
        if (fire)         state_n = ST_IDLE;
        else if (fall_ok) state_n = ST_LOW;
      end
      ST_LOW: begin
        if (add_more || hold_cmd) state_n = ST_OPEN;
        else if (bad_cmd)         state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  sew_mask_accum #(.NSEC(NSEC)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clear_i(fire || bad_cmd),
    .set_i  (open_first || add_more),
    .add_i  (dec_onehot),
    .mask_o (acc_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      erase_go_o <= 1'b0;
      abort_o    <= 1'b0;
      sel_mask_o <= '0;
      dq3_o      <= 1'b1;
    end else begin
      state      <= state_n;
      erase_go_o <= fire;
      abort_o    <= bad_cmd;
      sel_mask_o <= (fire || bad_cmd) ? acc_mask : '0;
      dq3_o      <= (state_n == ST_IDLE);
    end
  end

  // R10: the two pulses exclude each other
  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(erase_go_o && abort_o));
  // R10: mask output quiet without a pulse
  assert_quiet_mask_R10: assert property (@(posedge clk) disable iff (rst)
    !(erase_go_o || abort_o) |-> (sel_mask_o == '0));
  // R3: an erase always names at least one sector and ends the delay
  assert_go_mask_R3: assert property (@(posedge clk) disable iff (rst)
    erase_go_o |-> ((sel_mask_o != '0) && dq3_o));
  // R2: the delay status only drops after an accepted opening cycle
  assert_dq3_open_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(dq3_o) |-> $past(wr_rise_i && seq_ok_i && (cmd_i == CMD_SECTOR)));
  // R8: abort only follows a disallowed command
  assert_abort_cause_R8: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> $past(wr_rise_i && (cmd_i != CMD_SECTOR) && (cmd_i != CMD_HOLD)));
  // R8: the bitmap is empty once a pulse has reported it
  assert_mask_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (erase_go_o || abort_o) |-> (acc_mask == '0));
endmodule

// File: tb/sector_erase_window_bench.sv
module sector_erase_window_bench;
  localparam int ADDR_W = 19;
  localparam int NSEC   = 8;
  localparam int WIN    = 20;
  localparam int SH     = ADDR_W - 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_fall_i = 1'b0, wr_rise_i = 1'b0, seq_ok_i = 1'b0;
  logic [7:0] cmd_i = 8'h00;
  logic [ADDR_W-1:0] addr_i = '0;
  logic erase_go_o, abort_o, dq3_o;
  logic [NSEC-1:0] sel_mask_o;

  always #2.5 clk = ~clk;

  sector_erase_window #(.ADDR_W(ADDR_W), .NSEC(NSEC), .CLK_MHZ(1), .WINDOW_US(WIN))
    u_sector_erase_window (
      .clk(clk), .rst(rst), .wr_fall_i(wr_fall_i), .wr_rise_i(wr_rise_i),
      .seq_ok_i(seq_ok_i), .cmd_i(cmd_i), .addr_i(addr_i),
      .erase_go_o(erase_go_o), .abort_o(abort_o), .sel_mask_o(sel_mask_o), .dq3_o(dq3_o));

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference: 0 idle, 1 counting, 2 strobe low
  int m_st = 0, m_cnt = 0, m_mask = 0;
  int e_go = 0, e_ab = 0, e_mask = 0, e_dq3 = 1;

  always @(posedge clk) begin
    cyc++;
    e_go = 0; e_ab = 0; e_mask = 0;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_mask = 0; e_dq3 = 1;
    end else begin
      if (m_st == 0) begin
        if (wr_rise_i && seq_ok_i && cmd_i == 8'h30) begin
          m_mask = 1 << (addr_i >> SH); m_cnt = WIN - 1; m_st = 1;
        end
      end else if (m_st == 1) begin
        if (m_cnt == 0) begin
          e_go = 1; e_mask = m_mask; m_mask = 0; m_st = 0;
        end else if (wr_fall_i) begin
          m_st = 2; m_cnt = WIN - 1;
        end else m_cnt--;
      end else if (wr_rise_i) begin
        if (cmd_i == 8'h30) begin
          m_mask |= 1 << (addr_i >> SH); m_cnt = WIN - 1; m_st = 1;
        end else if (cmd_i == 8'hB0) begin
          m_cnt = WIN - 1; m_st = 1;
        end else begin
          e_ab = 1; e_mask = m_mask; m_mask = 0; m_st = 0;
        end
      end
      e_dq3 = (m_st == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 0) begin
      check(erase_go_o === e_go[0] && abort_o === e_ab[0] && dq3_o === e_dq3[0]
            && sel_mask_o === e_mask[NSEC-1:0],
            {cur_req, " model"}, {erase_go_o, abort_o, dq3_o, sel_mask_o},
            {e_go[0], e_ab[0], e_dq3[0], e_mask[NSEC-1:0]});
      if (erase_go_o && abort_o) check(0, "R10", 3, 0);
    end
  end

  function automatic logic [ADDR_W-1:0] mk(input int sec, input int off);
    return ADDR_W'((sec << SH) | off);
  endfunction

  task automatic rise(input logic [7:0] c, input logic [ADDR_W-1:0] a, input bit s);
    @(negedge clk); wr_rise_i = 1; cmd_i = c; addr_i = a; seq_ok_i = s;
    @(negedge clk); wr_rise_i = 0; seq_ok_i = 0; cmd_i = 8'h00;
  endtask

  task automatic strobe(input logic [7:0] c, input logic [ADDR_W-1:0] a, input int lowc);
    @(negedge clk); wr_fall_i = 1;
    @(negedge clk); wr_fall_i = 0;
    repeat (lowc) @(negedge clk);
    rise(c, a, 1'b0);
  endtask

  task automatic to_go(output int n);
    n = 0;
    while (!erase_go_o && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  int n;
  initial begin
    repeat (3) @(negedge clk);
    check(!erase_go_o && !abort_o && dq3_o && sel_mask_o == 0, "R1", {erase_go_o, abort_o, dq3_o}, 1);
    rst = 0;
    @(negedge clk);
    check(dq3_o === 1'b1, "R1", dq3_o, 1);

    cur_req = "R2";
    rise(8'h30, mk(2, 5), 1'b0);
    rise(8'h20, mk(2, 5), 1'b1);
    @(negedge clk); wr_fall_i = 1; @(negedge clk); wr_fall_i = 0;
    repeat (3) @(negedge clk);
    check(dq3_o === 1'b1, "R2", dq3_o, 1);

    cur_req = "R3";
    rise(8'h30, mk(5, 16'h1234), 1'b1);
    check(dq3_o === 1'b0, "R2", dq3_o, 0);
    to_go(n);
    check(n == WIN, "R3", n, WIN);
    check(sel_mask_o == 8'h20, "R3", sel_mask_o, 8'h20);

    cur_req = "R5";
    rise(8'h30, mk(7, 0), 1'b1);
    strobe(8'h30, mk(0, 99), 2);
    strobe(8'h30, mk(3, 7), 1);
    to_go(n);
    check(n == WIN, "R5", n, WIN);
    check(sel_mask_o == 8'h89, "R5", sel_mask_o, 8'h89);

    rise(8'h30, mk(4, 0), 1'b1);
    for (int s = 0; s < NSEC; s++) strobe(8'h30, mk(NSEC - 1 - s, s), 0);
    to_go(n);
    check(sel_mask_o == 8'hFF, "R5", sel_mask_o, 8'hFF);

    cur_req = "R6";
    rise(8'h30, mk(1, 0), 1'b1);
    repeat (WIN - 5) @(negedge clk);
    strobe(8'h30, mk(1, 55), 1);
    to_go(n);
    check(n == WIN, "R6", n, WIN);
    check(sel_mask_o == 8'h02, "R6", sel_mask_o, 8'h02);

    cur_req = "R7";
    rise(8'h30, mk(6, 0), 1'b1);
    repeat (WIN - 4) @(negedge clk);
    strobe(8'hB0, mk(2, 0), 1);
    check(!abort_o, "R7", abort_o, 0);
    to_go(n);
    check(n == WIN, "R7", n, WIN);
    check(sel_mask_o == 8'h40, "R7", sel_mask_o, 8'h40);

    cur_req = "R8";
    rise(8'h30, mk(3, 0), 1'b1);
    strobe(8'h30, mk(5, 0), 0);
    strobe(8'h80, mk(1, 0), 0);
    check(abort_o === 1'b1 && sel_mask_o == 8'h28, "R8", {abort_o, sel_mask_o}, 9'h128);
    check(dq3_o === 1'b1, "R8", dq3_o, 1);
    @(negedge clk);
    check(!abort_o && sel_mask_o == 0, "R10", {abort_o, sel_mask_o}, 0);
    to_go(n);
    check(n == 1000, "R8", n, 1000);

    cur_req = "R4";
    rise(8'h30, mk(0, 0), 1'b1);
    repeat (5) @(negedge clk);
    wr_fall_i = 1; @(negedge clk); wr_fall_i = 0;
    repeat (3 * WIN) @(negedge clk);
    check(!erase_go_o && dq3_o === 1'b0, "R4", {erase_go_o, dq3_o}, 0);
    rise(8'h30, mk(2, 0), 1'b0);
    to_go(n);
    check(n == WIN, "R4", n, WIN);
    check(sel_mask_o == 8'h05, "R4", sel_mask_o, 8'h05);

    cur_req = "R9";
    rise(8'h30, mk(6, 0), 1'b1);
    repeat (WIN - 1) @(negedge clk);
    wr_fall_i = 1; @(negedge clk); wr_fall_i = 0;
    check(erase_go_o === 1'b1 && sel_mask_o == 8'h40, "R9", {erase_go_o, sel_mask_o}, 9'h140);
    rise(8'h30, mk(1, 0), 1'b0);
    repeat (WIN + 3) @(negedge clk);
    check(dq3_o === 1'b1 && !erase_go_o, "R9", {dq3_o, erase_go_o}, 2);

    repeat (4) @(negedge clk);
    finish_up;
  end

  initial begin
    #(5.0 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up;
  end
endmodule